// File: doc/BRIEF.md
# CAN Operating Mode Handshake Controller

This block manages the handshake by which software moves a CAN controller into and out of two quiet modes: a low-power sleep mode and a configuration (freeze) mode. Software raises or drops a level request for each mode. The block answers with a confirm bit per mode, and software polls that bit. Hardware alone sets and clears the confirm bits.

Entry into a mode is held off while the protocol engine reports a frame in progress. The confirm bit sets only once that activity has ended. Exit is held off until the receive line shows a run of `IDLE_BITS` (default 11) consecutive recessive bit samples. A one-cycle bit-sample strobe stands in for the bit-timing logic. A dominant sample restarts the run.

When both modes are requested, freeze wins. The controller never confirms both modes at once. Out of reset the block behaves as if freeze were requested (parameter `RESET_IN_FREEZE`). It confirms freeze as soon as the bus is quiet and the request is held.

The controller is a seven-state machine. Its states and transitions are:

- `ST_NORMAL` moves to `ST_WAIT_FRZ` on a freeze request, otherwise to `ST_WAIT_SLP` on a sleep request.
- `ST_WAIT_FRZ` moves to `ST_FREEZE` when the bus is idle, and back to `ST_NORMAL` if the request is withdrawn.
- `ST_WAIT_SLP` moves to `ST_WAIT_FRZ` on a freeze request, to `ST_NORMAL` on withdrawal, and to `ST_SLEEP` when the bus is idle.
- `ST_FREEZE` moves to `ST_EXIT_FRZ` on withdrawal.
- `ST_SLEEP` moves to `ST_FREEZE` on a freeze request, otherwise to `ST_EXIT_SLP` on withdrawal.
- `ST_EXIT_FRZ` returns to `ST_FREEZE` on a new request, and moves to `ST_NORMAL` once the recessive run completes.
- `ST_EXIT_SLP` moves to `ST_FREEZE` on a freeze request, returns to `ST_SLEEP` on a sleep request, and moves to `ST_NORMAL` once the run completes.

Top module: `canmh_mode_ctrl`

## Requirements
- R1: While `rst_n` is low both confirm outputs are 0. With `RESET_IN_FREEZE`=1 and `frz_req` held at 1, `frz_ack` rises on the first clock edge after reset release at which `bus_busy` is 0.
- R2: From normal mode a freeze request is confirmed on the second clock edge after the request, if `bus_busy` is 0. While `bus_busy` is 1, `frz_ack` stays 0.
- R3: From normal mode a sleep request (with `frz_req`=0) is confirmed on the second clock edge after the request, if `bus_busy` is 0. While `bus_busy` is 1, `slp_ack` stays 0.
- R4: After a confirmed mode's request is withdrawn, its confirm bit stays 1 until `IDLE_BITS` consecutive strobed samples with `rx_bit`=1 (recessive) have been taken. It clears on the clock edge after the edge that took the last of those samples.
- R5: A strobed sample with `rx_bit`=0 (dominant) during exit restarts the recessive count from zero.
- R6: Samples count only in cycles where `bit_strobe` is 1. A recessive line without a strobe never completes an exit.
- R7: When both requests are high, freeze is entered and `slp_ack` stays 0. The two confirm bits are never 1 together.
- R8: A request withdrawn before its confirm bit sets returns the block to normal mode without that bit ever rising.
- R9: If a request is raised again while its exit is still counting, the confirm bit stays 1 and the mode is resumed.
- R10: A freeze request while in sleep mode clears `slp_ack` and sets `frz_ack` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_req | input | 1 | Software sleep-mode request (level) |
| frz_req | input | 1 | Software freeze-mode request (level) |
| bus_busy | input | 1 | Protocol engine is transmitting or receiving a frame |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| bit_strobe | input | 1 | One-cycle pulse marking a bit sample point |
| slp_ack | output | 1 | Sleep mode confirmed |
| frz_ack | output | 1 | Freeze mode confirmed |

## Verification
On every cycle the checker enforces four rules:

- The two confirm bits are mutually exclusive.
- A freeze request forbids a sleep confirm on the next cycle.
- Each confirm bit rises only after a cycle with the bus idle.
- Each confirm bit falls to normal mode only right after the recessive run completed, and a dominant or missing strobe never completes the run.

Some behaviours need a sequence of stimulus, so only the bench scenarios show them:

- the exact cycle counts of entry and exit;
- a withdrawn request leaving no trace;
- a re-request during exit resuming the mode;
- the reset-to-freeze start.

// File: rtl/canmh_pkg.sv
package canmh_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_WAIT_FRZ = 3'd1,
        ST_WAIT_SLP = 3'd2,
        ST_FREEZE   = 3'd3,
        ST_SLEEP    = 3'd4,
        ST_EXIT_FRZ = 3'd5,
        ST_EXIT_SLP = 3'd6
    } mode_state_t;

endpackage

// File: rtl/canmh_req_arb.sv
// Resolves simultaneous mode requests: freeze outranks sleep.
module canmh_req_arb (
    input  logic slp_req,
    input  logic frz_req,
    output logic want_frz,
    output logic want_slp
);
    always_comb begin
        want_frz = frz_req;
        want_slp = slp_req & ~frz_req;
    end
endmodule

// File: rtl/canmh_idle_run.sv
// Counts consecutive recessive bit samples while enabled.
module canmh_idle_run #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_strobe,
    input  logic rx_bit,
    output logic run_done
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] TARGET = CNT_W'(IDLE_BITS);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!enable) begin
            run_cnt <= '0;
        end else if (bit_strobe) begin
            if (!rx_bit)
                run_cnt <= '0;
            else if (run_cnt != TARGET)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign run_done = enable && (run_cnt == TARGET);
endmodule

// File: rtl/canmh_mode_ctrl.sv
module canmh_mode_ctrl #(
    parameter int IDLE_BITS       = 11,
    parameter bit RESET_IN_FREEZE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slp_req,
    input  logic frz_req,
    input  logic bus_busy,
    input  logic rx_bit,
    input  logic bit_strobe,
    output logic slp_ack,
    output logic frz_ack
);
    import canmh_pkg::*;

    localparam mode_state_t RESET_STATE = RESET_IN_FREEZE ? ST_WAIT_FRZ : ST_NORMAL;

    mode_state_t state_q, state_d;
    logic want_frz, want_slp;
    logic count_en, run_done;

    canmh_req_arb u_arb (
        .slp_req  (slp_req),
        .frz_req  (frz_req),
        .want_frz (want_frz),
        .want_slp (want_slp)
    );

    assign count_en = (state_q == ST_EXIT_FRZ) || (state_q == ST_EXIT_SLP);

    canmh_idle_run #(.IDLE_BITS(IDLE_BITS)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (count_en),
        .bit_strobe (bit_strobe),
        .rx_bit     (rx_bit),
        .run_done   (run_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (want_frz)      state_d = ST_WAIT_FRZ;
                else if (want_slp) state_d = ST_WAIT_SLP;
            end
            ST_WAIT_FRZ: begin
                if (!want_frz)     state_d = ST_NORMAL;
                else if (!bus_busy) state_d = ST_FREEZE;
            end
            ST_WAIT_SLP: begin
                if (want_frz)      state_d = ST_WAIT_FRZ;
                else if (!want_slp) state_d = ST_NORMAL;
                else if (!bus_busy) state_d = ST_SLEEP;
            end
            ST_FREEZE: begin
                if (!want_frz)     state_d = ST_EXIT_FRZ;
            end
            ST_SLEEP: begin
                if (want_frz)      state_d = ST_FREEZE;
                else if (!want_slp) state_d = ST_EXIT_SLP;
            end
            ST_EXIT_FRZ: begin
                if (want_frz)      state_d = ST_FREEZE;
                else if (run_done) state_d = ST_NORMAL;
            end
            ST_EXIT_SLP: begin
                if (want_frz)      state_d = ST_FREEZE;
                else if (want_slp) state_d = ST_SLEEP;
                else if (run_done) state_d = ST_NORMAL;
            end
            default:               state_d = ST_NORMAL;
        endcase
    end

    always_comb begin
        slp_ack = 1'b0;
        frz_ack = 1'b0;
        unique case (state_q)
            ST_FREEZE, ST_EXIT_FRZ: frz_ack = 1'b1;
            ST_SLEEP,  ST_EXIT_SLP: slp_ack = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/canmh_mode_ctrl_chk.sv
module canmh_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic frz_req,
    input logic bus_busy,
    input logic rx_bit,
    input logic bit_strobe,
    input logic slp_ack,
    input logic frz_ack,
    input logic run_done
);
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(slp_ack && frz_ack)); // R7

    AST_FRZ_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        frz_req |=> !slp_ack); // R10

    AST_FRZ_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frz_ack) && !$past(slp_ack)) |-> !$past(bus_busy)); // R2

    AST_SLP_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slp_ack) |-> !$past(bus_busy)); // R3

    AST_FRZ_EXIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frz_ack) |-> $past(run_done)); // R4

    AST_SLP_EXIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(slp_ack) && !frz_ack) |-> $past(run_done)); // R4

    AST_DOMINANT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !rx_bit) |=> !run_done); // R5

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_strobe && !run_done) |=> !run_done); // R6
endmodule

bind canmh_mode_ctrl canmh_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frz_req    (frz_req),
    .bus_busy   (bus_busy),
    .rx_bit     (rx_bit),
    .bit_strobe (bit_strobe),
    .slp_ack    (slp_ack),
    .frz_ack    (frz_ack),
    .run_done   (run_done)
);

// File: tb/canmh_mode_ctrl_bench.sv
module canmh_mode_ctrl_bench;
    localparam int IDLE = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slp_req = 1'b0, frz_req = 1'b1, bus_busy = 1'b1;
    logic rx_bit = 1'b1, bit_strobe = 1'b0;
    logic slp_ack, frz_ack;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    canmh_mode_ctrl #(.IDLE_BITS(IDLE), .RESET_IN_FREEZE(1'b1)) u_canmh_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .slp_req(slp_req), .frz_req(frz_req),
        .bus_busy(bus_busy), .rx_bit(rx_bit), .bit_strobe(bit_strobe),
        .slp_ack(slp_ack), .frz_ack(frz_ack)
    );

    // {slp_req, frz_req, bus_busy, rx_bit, bit_strobe, exp_slp, exp_frz}
    localparam int NV = 8;
    localparam logic [6:0] VECS [0:NV-1] = '{
        7'b0001000,  // idle in normal mode
        7'b1011000,  // sleep requested while busy (R3)
        7'b1011000,  // still busy (R3)
        7'b1001010,  // bus idle -> sleep confirmed (R3)
        7'b1101001,  // freeze while sleeping (R10)
        7'b0101001,  // freeze held
        7'b0001001,  // withdrawn -> exit counting, ack held
        7'b0101001   // re-request during exit (R9)
    };

    function automatic string row_tag(int i);
        case (i)
            1, 2, 3: return "R3";
            4:       return "R10";
            7:       return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic exp_s, logic exp_f);
        checks++;
        if (slp_ack !== exp_s || frz_ack !== exp_f) begin
            errors++;
            $display("FAIL %s: slp_ack=%b frz_ack=%b expected slp_ack=%b frz_ack=%b",
                     tag, slp_ack, frz_ack, exp_s, exp_f);
        end
    endtask

    task automatic strobe_bit(logic rx);
        rx_bit = rx;
        bit_strobe = 1'b1;
        step();
        bit_strobe = 1'b0;
        rx_bit = 1'b1;
    endtask

    task automatic finish_exit();
        for (int k = 0; k < IDLE; k++) strobe_bit(1'b1);
        step();
    endtask

    initial begin
        // R1: reset state, then reset-to-freeze entry once the bus is idle
        repeat (3) step();
        check("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 busy after reset", 1'b0, 1'b0);
        bus_busy = 1'b0;
        step();
        check("R1 freeze after reset", 1'b0, 1'b1);

        // Exit handling: R6, R5, R4
        frz_req = 1'b0;
        step();
        check("R4 exit started", 1'b0, 1'b1);
        repeat (20) step();
        check("R6 no strobe", 1'b0, 1'b1);
        for (int k = 0; k < IDLE - 1; k++) strobe_bit(1'b1);
        strobe_bit(1'b0);
        for (int k = 0; k < IDLE - 1; k++) strobe_bit(1'b1);
        check("R5 dominant restart", 1'b0, 1'b1);
        strobe_bit(1'b1);
        check("R4 last sample edge", 1'b0, 1'b1);
        step();
        check("R4 freeze exit", 1'b0, 1'b0);

        // Table of vectors from normal mode
        for (int i = 0; i < NV; i++) begin
            {slp_req, frz_req, bus_busy, rx_bit, bit_strobe} = VECS[i][6:2];
            step();
            check(row_tag(i), VECS[i][1], VECS[i][0]);
        end
        bit_strobe = 1'b0;

        // Leave freeze
        slp_req = 1'b0; frz_req = 1'b0; bus_busy = 1'b0;
        step();
        finish_exit();
        check("R4 second exit", 1'b0, 1'b0);

        // R8: withdrawals before entry
        slp_req = 1'b1; bus_busy = 1'b1;
        step(); step();
        slp_req = 1'b0;
        step();
        bus_busy = 1'b0;
        step(); step();
        check("R8 sleep withdrawn", 1'b0, 1'b0);
        frz_req = 1'b1; bus_busy = 1'b1;
        step();
        frz_req = 1'b0;
        step();
        bus_busy = 1'b0;
        step(); step();
        check("R8 freeze withdrawn", 1'b0, 1'b0);

        // R2: freeze entry timing from normal
        frz_req = 1'b1;
        step();
        check("R2 first edge", 1'b0, 1'b0);
        step();
        check("R2 second edge", 1'b0, 1'b1);
        frz_req = 1'b0;
        step();
        finish_exit();

        // R7: both requested at once
        slp_req = 1'b1; frz_req = 1'b1;
        step(); step();
        check("R7 simultaneous", 1'b0, 1'b1);
        slp_req = 1'b0; frz_req = 1'b0;
        step();
        finish_exit();
        check("R7 back to normal", 1'b0, 1'b0);

        // R4 for sleep exit
        slp_req = 1'b1;
        step(); step();
        check("R3 sleep entry", 1'b1, 1'b0);
        slp_req = 1'b0;
        step();
        for (int k = 0; k < IDLE; k++) strobe_bit(1'b1);
        check("R4 sleep held", 1'b1, 1'b0);
        step();
        check("R4 sleep exit", 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule